// File: doc/BRIEF.md
# Flash Bank Transaction Emulator

This block is a synthesizable behavioural stand-in for a multi-bank flash array and its controller. It takes read, program, page-erase and bank-erase requests, each carrying a bank select, a partition select (data or info) and a word address. Every request has two phases: a single-cycle acceptance pulse, and later a single-cycle completion pulse. Reads complete within one or two cycles and return data in the completion cycle. Program and erase operations take many cycles, set by parameters, so that surrounding logic can be exercised against realistic long gaps between acceptance and completion.

Only one transaction is in flight at a time. A running erase can be suspended: the block confirms the suspension in the cycle it sees the request, stops erasing, and still ends the erase with a normal completion pulse. A program whose type is not marked as supported is refused and nothing is written. Instead an error bit for the addressed bank is set. The per-bank error bits drive a level interrupt and are cleared by writing ones. The array contents live in internal registers that start out erased (all ones).

Top module: `flash_txn_emu`

## Requirements
- R1: After reset every word of every bank and partition reads as all ones. `ack_o`, `done_o`, `suspend_ack_o`, `err_irq_o`, `rd_data_o` and `err_status_o` are all zero.
- R2: While idle, a request on any of the four request inputs is acknowledged with a one-cycle `ack_o` in the same cycle. If several are raised together, read wins over program, program over page erase, and page erase over bank erase. While a transaction is outstanding, no request is acknowledged, and `ack_o` and `done_o` never coincide.
- R3: A read completes `READ_LAT` cycles after its acknowledge. `rd_data_o` carries the stored word in the `done_o` cycle and is zero in every other cycle.
- R4: A program completes `PROG_LAT` cycles after its acknowledge. The stored word becomes the old word bitwise AND the program data.
- R5: A page erase (page = `PAGE_WORDS` consecutive words) sets the words of the addressed page to all ones, one at a time in rising address order. Each word takes `ERASE_LAT` cycles, so `done_o` comes `PAGE_WORDS*ERASE_LAT` cycles after the acknowledge. Other pages are unchanged.
- R6: A bank erase sets every word of both partitions of the selected bank to all ones, data partition first. `done_o` comes `2*PAGES*PAGE_WORDS*ERASE_LAT` cycles after the acknowledge, and the other bank is unchanged.
- R7: `erase_suspend_i` high during an erase gives `suspend_ack_o` in that same cycle, and no further word is erased. This includes the word whose slot would have ended in that cycle. `done_o` follows `SUSP_LAT` cycles later. Words not yet erased keep their old contents.
- R8: `erase_suspend_i` while idle or during a read or program produces no `suspend_ack_o` and does not change the timing of the running transaction.
- R9: `prog_type_i` is an index into `prog_type_avail_i`. If the indexed bit is 0, the program is acknowledged, completes one cycle later, and leaves memory unchanged. Bit `bank_sel_i` of the error status is set from the next cycle on.
- R10: `err_status_o` holds one bit per bank, where bit b is the error source of bank b. A 1 on `err_clear_i[b]` clears bit b at the next edge. A set in the same cycle wins over a clear. `err_irq_o` is high exactly when some status bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| rd_req_i | input | 1 | Read request |
| prog_req_i | input | 1 | Program request |
| page_erase_req_i | input | 1 | Page-erase request |
| bank_erase_req_i | input | 1 | Bank-erase request |
| bank_sel_i | input | BANK_W | Bank targeted by the request |
| info_sel_i | input | 1 | Partition: 0 data, 1 info |
| addr_i | input | ADDR_W | Word address inside the partition |
| prog_data_i | input | DATA_W | Program data |
| prog_type_i | input | PTYPE_W | Program type index |
| prog_type_avail_i | input | PROG_TYPES | Supported program types, one bit per type |
| erase_suspend_i | input | 1 | Erase-suspend request |
| ack_o | output | 1 | Request accepted (one cycle) |
| done_o | output | 1 | Transaction finished (one cycle) |
| rd_data_o | output | DATA_W | Read data, valid with `done_o` of a read |
| suspend_ack_o | output | 1 | Suspension started (one cycle) |
| err_clear_i | input | NUM_BANKS | Write-one-to-clear strobes for the status bits |
| err_status_o | output | NUM_BANKS | Per-bank error status |
| err_irq_o | output | 1 | Level error interrupt |

## Verification
Two pairs of events can land on the same clock edge, and both are provoked on purpose. In the first, a suspend request is timed to arrive in the exact cycle whose edge would erase the next word of a page. The reference model expects the suspension to win: the acknowledge is in that cycle and the word keeps its programmed value, which a later read exposes. In the second, a refused program on a bank whose error bit is already set is issued in the same cycle as a write-one-clear of that bit. The model expects the bit and the interrupt to stay high. A clear alone in a later cycle must drop both.

// File: rtl/flash_emu_pkg.sv
package flash_emu_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_WAIT,
        ST_ERASE,
        ST_SUSP
    } fe_state_e;

    typedef enum logic [2:0] {
        OP_READ,
        OP_PROG,
        OP_BADPROG,
        OP_PAGE_ERASE,
        OP_BANK_ERASE
    } fe_op_e;

    function automatic int fe_max4(input int a, input int b, input int c, input int d);
        int m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction

endpackage

// File: rtl/flash_emu_store.sv
module flash_emu_store #(
    parameter int DATA_W = 16,
    parameter int IDX_W  = 6
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [IDX_W-1:0]  idx_i,
    input  logic              wr_en_i,
    input  logic              wr_erase_i,
    input  logic [DATA_W-1:0] wr_data_i,
    output logic [DATA_W-1:0] rd_data_o
);
    localparam int DEPTH = 2 ** IDX_W;

    logic [DATA_W-1:0] mem_d [DEPTH];
    logic [DATA_W-1:0] mem_q [DEPTH];

    always_comb begin
        mem_d = mem_q;
        if (wr_en_i) begin
            if (wr_erase_i) begin
                mem_d[idx_i] = {DATA_W{1'b1}};
            end else begin
                mem_d[idx_i] = mem_q[idx_i] & wr_data_i;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= {DATA_W{1'b1}};
            end
        end else begin
            mem_q <= mem_d;
        end
    end

    assign rd_data_o = mem_q[idx_i];

    // R4: a program only clears bits of the addressed word
    p_prog_and_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && !wr_erase_i) |=>
            (mem_q[$past(idx_i)] == ($past(rd_data_o) & $past(wr_data_i))));

    // R5: an erase write leaves the addressed word all ones
    p_erase_ones_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && wr_erase_i) |=> (mem_q[$past(idx_i)] == {DATA_W{1'b1}}));

endmodule

// File: rtl/flash_emu_err.sv
module flash_emu_err #(
    parameter int NUM_BANKS = 2
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic [NUM_BANKS-1:0] set_i,
    input  logic [NUM_BANKS-1:0] clr_i,
    output logic [NUM_BANKS-1:0] status_o,
    output logic                 irq_o
);
    typedef struct packed {
        logic [NUM_BANKS-1:0] status;
    } err_t;

    err_t e_d, e_q;

    always_comb begin
        e_d = e_q;
        e_d.status = (e_q.status & ~clr_i) | set_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            e_q <= '0;
        end else begin
            e_q <= e_d;
        end
    end

    assign status_o = e_q.status;
    assign irq_o    = |e_q.status;

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bit_chk
        // R10: a set in the same cycle as a clear wins
        p_set_wins_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
            set_i[b] |=> status_o[b]);
        // R10: a clear alone drops the bit
        p_clear_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (clr_i[b] && !set_i[b]) |=> !status_o[b]);
        // R10: without set or clear the bit holds
        p_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (!clr_i[b] && !set_i[b]) |=> $stable(status_o[b]));
    end

endmodule

// File: rtl/flash_emu_seq.sv
module flash_emu_seq
    import flash_emu_pkg::*;
#(
    parameter int NUM_BANKS  = 2,
    parameter int PAGES      = 4,
    parameter int PAGE_WORDS = 4,
    parameter int DATA_W     = 16,
    parameter int PROG_TYPES = 2,
    parameter int READ_LAT   = 2,
    parameter int PROG_LAT   = 6,
    parameter int ERASE_LAT  = 5,
    parameter int SUSP_LAT   = 3,
    localparam int BANK_W    = $clog2(NUM_BANKS),
    localparam int PAGE_W    = $clog2(PAGES),
    localparam int WORD_W    = $clog2(PAGE_WORDS),
    localparam int ADDR_W    = PAGE_W + WORD_W,
    localparam int IDX_W     = BANK_W + 1 + ADDR_W,
    localparam int PTYPE_W   = $clog2(PROG_TYPES)
) (
    input  logic                  clk_i,
    input  logic                  rst_ni,
    input  logic                  rd_req_i,
    input  logic                  prog_req_i,
    input  logic                  page_erase_req_i,
    input  logic                  bank_erase_req_i,
    input  logic [BANK_W-1:0]     bank_sel_i,
    input  logic                  info_sel_i,
    input  logic [ADDR_W-1:0]     addr_i,
    input  logic [DATA_W-1:0]     prog_data_i,
    input  logic [PTYPE_W-1:0]    prog_type_i,
    input  logic [PROG_TYPES-1:0] prog_type_avail_i,
    input  logic                  erase_suspend_i,
    output logic                  ack_o,
    output logic                  done_o,
    output logic                  suspend_ack_o,
    output logic                  rd_valid_o,
    output logic [IDX_W-1:0]      mem_idx_o,
    output logic                  wr_en_o,
    output logic                  wr_erase_o,
    output logic [DATA_W-1:0]     wr_data_o,
    output logic [NUM_BANKS-1:0]  err_set_o
);
    localparam int MAX_LAT = fe_max4(READ_LAT, PROG_LAT, ERASE_LAT, SUSP_LAT);
    localparam int CNT_W   = $clog2(MAX_LAT + 1);
    localparam int WALK_W  = 1 + ADDR_W;

    localparam logic [CNT_W-1:0]  C_READ  = CNT_W'(READ_LAT - 1);
    localparam logic [CNT_W-1:0]  C_PROG  = CNT_W'(PROG_LAT - 1);
    localparam logic [CNT_W-1:0]  C_ERASE = CNT_W'(ERASE_LAT - 1);
    localparam logic [CNT_W-1:0]  C_SUSP  = CNT_W'(SUSP_LAT - 1);
    localparam logic [WALK_W-1:0] LAST_PAGE_WORD = WALK_W'(PAGE_WORDS - 1);
    localparam logic [WALK_W-1:0] LAST_BANK_WORD = WALK_W'(2 * PAGES * PAGE_WORDS - 1);

    typedef struct packed {
        fe_state_e          st;
        fe_op_e             op;
        logic [BANK_W-1:0]  bank;
        logic               part;
        logic [ADDR_W-1:0]  addr;
        logic [DATA_W-1:0]  data;
        logic [CNT_W-1:0]   cnt;
        logic [WALK_W-1:0]  walk;
    } seq_t;

    seq_t s_d, s_q;

    logic              any_req;
    logic              type_ok;
    logic [IDX_W-1:0]  erase_idx;
    logic [WALK_W-1:0] walk_last;

    assign any_req = rd_req_i | prog_req_i | page_erase_req_i | bank_erase_req_i;
    assign type_ok = prog_type_avail_i[prog_type_i];

    always_comb begin
        if (s_q.op == OP_PAGE_ERASE) begin
            erase_idx = {s_q.bank, s_q.part, s_q.addr[ADDR_W-1:WORD_W], s_q.walk[WORD_W-1:0]};
            walk_last = LAST_PAGE_WORD;
        end else begin
            erase_idx = {s_q.bank, s_q.walk};
            walk_last = LAST_BANK_WORD;
        end
    end

    always_comb begin
        s_d           = s_q;
        ack_o         = 1'b0;
        done_o        = 1'b0;
        suspend_ack_o = 1'b0;
        rd_valid_o    = 1'b0;
        wr_en_o       = 1'b0;
        wr_erase_o    = 1'b0;
        err_set_o     = '0;
        mem_idx_o     = {s_q.bank, s_q.part, s_q.addr};
        wr_data_o     = s_q.data;

        unique case (s_q.st)
            ST_IDLE: begin
                if (any_req) begin
                    ack_o     = 1'b1;
                    s_d.bank  = bank_sel_i;
                    s_d.part  = info_sel_i;
                    s_d.addr  = addr_i;
                    s_d.data  = prog_data_i;
                    s_d.walk  = '0;
                    if (rd_req_i) begin
                        s_d.op  = OP_READ;
                        s_d.st  = ST_WAIT;
                        s_d.cnt = C_READ;
                    end else if (prog_req_i) begin
                        s_d.st = ST_WAIT;
                        if (type_ok) begin
                            s_d.op  = OP_PROG;
                            s_d.cnt = C_PROG;
                        end else begin
                            s_d.op  = OP_BADPROG;
                            s_d.cnt = '0;
                            err_set_o[bank_sel_i] = 1'b1;
                        end
                    end else if (page_erase_req_i) begin
                        s_d.op  = OP_PAGE_ERASE;
                        s_d.st  = ST_ERASE;
                        s_d.cnt = C_ERASE;
                    end else begin
                        s_d.op  = OP_BANK_ERASE;
                        s_d.st  = ST_ERASE;
                        s_d.cnt = C_ERASE;
                    end
                end
            end
            ST_WAIT: begin
                if (s_q.cnt == '0) begin
                    done_o     = 1'b1;
                    s_d.st     = ST_IDLE;
                    rd_valid_o = (s_q.op == OP_READ);
                    wr_en_o    = (s_q.op == OP_PROG);
                end else begin
                    s_d.cnt = s_q.cnt - 1'b1;
                end
            end
            ST_ERASE: begin
                mem_idx_o = erase_idx;
                if (erase_suspend_i) begin
                    suspend_ack_o = 1'b1;
                    s_d.st        = ST_SUSP;
                    s_d.cnt       = C_SUSP;
                end else if (s_q.cnt == '0) begin
                    wr_en_o    = 1'b1;
                    wr_erase_o = 1'b1;
                    if (s_q.walk == walk_last) begin
                        done_o = 1'b1;
                        s_d.st = ST_IDLE;
                    end else begin
                        s_d.walk = s_q.walk + 1'b1;
                        s_d.cnt  = C_ERASE;
                    end
                end else begin
                    s_d.cnt = s_q.cnt - 1'b1;
                end
            end
            ST_SUSP: begin
                if (s_q.cnt == '0) begin
                    done_o = 1'b1;
                    s_d.st = ST_IDLE;
                end else begin
                    s_d.cnt = s_q.cnt - 1'b1;
                end
            end
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            s_q    <= '0;
            s_q.st <= ST_IDLE;
            s_q.op <= OP_READ;
        end else begin
            s_q <= s_d;
        end
    end

    // R2: one transaction at a time, acceptance never repeats back to back
    p_one_outstanding_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ack_o |=> !ack_o);

    // R2: acceptance and completion are separate events
    p_ack_done_excl_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(ack_o && done_o));

    // R7: no word is erased after a suspension was confirmed
    p_susp_stops_erase_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        suspend_ack_o |=> !wr_en_o);

    // R9: a refused program completes next cycle without writing
    p_bad_prog_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ack_o && !rd_req_i && prog_req_i && !type_ok) |=> (done_o && !wr_en_o));

endmodule

// File: rtl/flash_txn_emu.sv
module flash_txn_emu #(
    parameter int NUM_BANKS  = 2,
    parameter int PAGES      = 4,
    parameter int PAGE_WORDS = 4,
    parameter int DATA_W     = 16,
    parameter int PROG_TYPES = 2,
    parameter int READ_LAT   = 2,
    parameter int PROG_LAT   = 6,
    parameter int ERASE_LAT  = 5,
    parameter int SUSP_LAT   = 3,
    localparam int BANK_W    = $clog2(NUM_BANKS),
    localparam int ADDR_W    = $clog2(PAGES) + $clog2(PAGE_WORDS),
    localparam int IDX_W     = BANK_W + 1 + ADDR_W,
    localparam int PTYPE_W   = $clog2(PROG_TYPES)
) (
    input  logic                  clk_i,
    input  logic                  rst_ni,
    input  logic                  rd_req_i,
    input  logic                  prog_req_i,
    input  logic                  page_erase_req_i,
    input  logic                  bank_erase_req_i,
    input  logic [BANK_W-1:0]     bank_sel_i,
    input  logic                  info_sel_i,
    input  logic [ADDR_W-1:0]     addr_i,
    input  logic [DATA_W-1:0]     prog_data_i,
    input  logic [PTYPE_W-1:0]    prog_type_i,
    input  logic [PROG_TYPES-1:0] prog_type_avail_i,
    input  logic                  erase_suspend_i,
    output logic                  ack_o,
    output logic                  done_o,
    output logic [DATA_W-1:0]     rd_data_o,
    output logic                  suspend_ack_o,
    input  logic [NUM_BANKS-1:0]  err_clear_i,
    output logic [NUM_BANKS-1:0]  err_status_o,
    output logic                  err_irq_o
);
    logic                 rd_valid;
    logic [IDX_W-1:0]     mem_idx;
    logic                 wr_en;
    logic                 wr_erase;
    logic [DATA_W-1:0]    wr_data;
    logic [DATA_W-1:0]    word;
    logic [NUM_BANKS-1:0] err_set;

    flash_emu_seq #(
        .NUM_BANKS  (NUM_BANKS),
        .PAGES      (PAGES),
        .PAGE_WORDS (PAGE_WORDS),
        .DATA_W     (DATA_W),
        .PROG_TYPES (PROG_TYPES),
        .READ_LAT   (READ_LAT),
        .PROG_LAT   (PROG_LAT),
        .ERASE_LAT  (ERASE_LAT),
        .SUSP_LAT   (SUSP_LAT)
    ) u_seq (
        .clk_i             (clk_i),
        .rst_ni            (rst_ni),
        .rd_req_i          (rd_req_i),
        .prog_req_i        (prog_req_i),
        .page_erase_req_i  (page_erase_req_i),
        .bank_erase_req_i  (bank_erase_req_i),
        .bank_sel_i        (bank_sel_i),
        .info_sel_i        (info_sel_i),
        .addr_i            (addr_i),
        .prog_data_i       (prog_data_i),
        .prog_type_i       (prog_type_i),
        .prog_type_avail_i (prog_type_avail_i),
        .erase_suspend_i   (erase_suspend_i),
        .ack_o             (ack_o),
        .done_o            (done_o),
        .suspend_ack_o     (suspend_ack_o),
        .rd_valid_o        (rd_valid),
        .mem_idx_o         (mem_idx),
        .wr_en_o           (wr_en),
        .wr_erase_o        (wr_erase),
        .wr_data_o         (wr_data),
        .err_set_o         (err_set)
    );

    flash_emu_store #(
        .DATA_W (DATA_W),
        .IDX_W  (IDX_W)
    ) u_store (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .idx_i      (mem_idx),
        .wr_en_i    (wr_en),
        .wr_erase_i (wr_erase),
        .wr_data_i  (wr_data),
        .rd_data_o  (word)
    );

    flash_emu_err #(
        .NUM_BANKS (NUM_BANKS)
    ) u_err (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .set_i    (err_set),
        .clr_i    (err_clear_i),
        .status_o (err_status_o),
        .irq_o    (err_irq_o)
    );

    assign rd_data_o = rd_valid ? word : '0;

endmodule

// File: tb/flash_txn_emu_tb_top.sv
module flash_txn_emu_tb_top;
    localparam int NB   = 2;
    localparam int PG   = 4;
    localparam int PW   = 4;
    localparam int DW   = 16;
    localparam int RL   = 2;
    localparam int PL   = 6;
    localparam int EL   = 5;
    localparam int SL   = 3;
    localparam int WPB  = PG * PW;
    localparam int DEPTH = NB * 2 * WPB;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic          rd_req = 0, prog_req = 0, pg_req = 0, bk_req = 0;
    logic          bank = 0, part = 0;
    logic [3:0]    addr = '0;
    logic [DW-1:0] pdata = '0;
    logic          ptype = 0;
    logic [1:0]    avail = 2'b01;
    logic          susp = 0;
    logic [NB-1:0] eclr = '0;
    logic          ack, done, sack, irq;
    logic [DW-1:0] rdata;
    logic [NB-1:0] estat;

    flash_txn_emu dut_i (
        .clk_i(clk), .rst_ni(rst_n),
        .rd_req_i(rd_req), .prog_req_i(prog_req),
        .page_erase_req_i(pg_req), .bank_erase_req_i(bk_req),
        .bank_sel_i(bank), .info_sel_i(part), .addr_i(addr),
        .prog_data_i(pdata), .prog_type_i(ptype), .prog_type_avail_i(avail),
        .erase_suspend_i(susp),
        .ack_o(ack), .done_o(done), .rd_data_o(rdata), .suspend_ack_o(sack),
        .err_clear_i(eclr), .err_status_o(estat), .err_irq_o(irq)
    );

    int n_chk = 0;
    int n_fail = 0;
    string rd_tag = "R3";

    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    // ---------------- reference model ----------------
    logic [DW-1:0] m_mem [DEPTH];
    logic [NB-1:0] m_err = '0;
    int m_mode = 0, m_k = 0, m_op = 0, m_lat = 0, m_base = 0, m_cnt = 0, m_idx = 0;
    logic [DW-1:0] m_data;
    initial for (int i = 0; i < DEPTH; i++) m_mem[i] = '1;

    function automatic int widx(input int b, input int p, input int a);
        return b * 2 * WPB + p * WPB + a;
    endfunction

    always @(negedge clk) begin
        if (rst_n) begin
            logic e_ack, e_done, e_susp;
            logic [DW-1:0] e_rd;
            logic [NB-1:0] set_v;
            string dtag;
            int entry;
            e_ack = 0; e_done = 0; e_susp = 0; e_rd = '0; set_v = '0; dtag = "R2";
            entry = m_mode;
            case (m_mode)
                0: if (rd_req | prog_req | pg_req | bk_req) begin
                    e_ack = 1; m_k = 0; m_data = pdata;
                    m_idx = widx(bank, part, addr);
                    if (rd_req) begin m_op = 0; m_lat = RL; m_mode = 1; end
                    else if (prog_req) begin
                        m_mode = 1;
                        if (avail[ptype]) begin m_op = 1; m_lat = PL; end
                        else begin m_op = 2; m_lat = 1; set_v[bank] = 1'b1; end
                    end else if (pg_req) begin
                        m_op = 3; m_mode = 2; m_cnt = PW;
                        m_base = widx(bank, part, (addr / PW) * PW);
                    end else begin
                        m_op = 4; m_mode = 2; m_cnt = 2 * WPB; m_base = bank * 2 * WPB;
                    end
                end
                1: begin
                    m_k++;
                    if (m_k == m_lat) begin
                        e_done = 1; m_mode = 0;
                        dtag = (m_op == 0) ? "R3" : (m_op == 1) ? "R4" : "R9";
                        if (m_op == 0) e_rd = m_mem[m_idx];
                        if (m_op == 1) m_mem[m_idx] = m_mem[m_idx] & m_data;
                    end
                end
                2: begin
                    m_k++;
                    if (susp) begin
                        e_susp = 1; m_mode = 3; m_k = 0;
                    end else if (m_k % EL == 0) begin
                        m_mem[m_base + m_k / EL - 1] = '1;
                        if (m_k / EL == m_cnt) begin
                            e_done = 1; m_mode = 0;
                            dtag = (m_op == 3) ? "R5" : "R6";
                        end
                    end
                end
                default: begin
                    m_k++;
                    if (m_k == SL) begin e_done = 1; m_mode = 0; dtag = "R7"; end
                end
            endcase
            chk("R2", "ack_o", 32'(ack), 32'(e_ack));
            chk(dtag, "done_o", 32'(done), 32'(e_done));
            chk((entry == 2) ? "R7" : "R8", "suspend_ack_o", 32'(sack), 32'(e_susp));
            chk(e_done ? rd_tag : "R3", "rd_data_o", 32'(rdata), 32'(e_rd));
            chk("R10", "err_status_o", 32'(estat), 32'(m_err));
            chk("R10", "err_irq_o", 32'(irq), 32'(|m_err));
            m_err = (m_err & ~eclr) | set_v;
        end
    end

    // ---------------- stimulus ----------------
    task automatic issue(input logic [3:0] req, input int b, input int p, input int a,
                         input logic [DW-1:0] d, input int t, input logic [NB-1:0] clr);
        @(posedge clk); #1;
        {bk_req, pg_req, prog_req, rd_req} = req;
        bank = 1'(b); part = 1'(p); addr = 4'(a); pdata = d; ptype = 1'(t); eclr = clr;
        for (int i = 0; i < 2000; i++) begin
            @(negedge clk);
            if (ack) break;
        end
        @(posedge clk); #1;
        {bk_req, pg_req, prog_req, rd_req} = '0;
        eclr = '0;
    endtask

    task automatic wait_done();
        for (int i = 0; i < 2000; i++) begin
            @(negedge clk);
            if (done) break;
        end
    endtask

    task automatic rd(input int b, input int p, input int a);
        issue(4'b0001, b, p, a, '0, 0, '0);
        wait_done();
    endtask

    task automatic prog(input int b, input int p, input int a, input logic [DW-1:0] d);
        issue(4'b0010, b, p, a, d, 0, '0);
        wait_done();
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        n_chk++;
        $display("FAIL watchdog: actual=expired expected=finished");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1: outputs at rest after reset
        chk("R1", "ack_o", 32'(ack), 0);
        chk("R1", "done_o", 32'(done), 0);
        chk("R1", "suspend_ack_o", 32'(sack), 0);
        chk("R1", "rd_data_o", 32'(rdata), 0);
        chk("R1", "err_status_o", 32'(estat), 0);
        chk("R1", "err_irq_o", 32'(irq), 0);
        rd_tag = "R1";
        rd(0, 0, 0); rd(1, 1, 15); rd(0, 1, 7);

        // R4: program is an AND into the stored word
        rd_tag = "R4";
        prog(0, 0, 5, 16'h0F0F); rd(0, 0, 5);
        prog(0, 0, 5, 16'h00FF); rd(0, 0, 5);
        prog(1, 1, 4, 16'h1234); rd(1, 1, 4);

        // R2: priority read over program, and no ack while busy
        rd_tag = "R2";
        issue(4'b0011, 0, 0, 5, 16'h0000, 0, '0);
        issue(4'b1100, 0, 0, 6, 16'h0000, 0, '0);   // page erase wins over bank erase, raised while busy
        wait_done();
        rd(0, 0, 5);

        // R5: page erase of page 1 in bank 0 data
        rd_tag = "R5";
        for (int w = 4; w < 8; w++) prog(0, 0, w, 16'(16'hA500 + w));
        issue(4'b0100, 0, 0, 6, '0, 0, '0);
        wait_done();
        for (int w = 3; w < 9; w++) rd(0, 0, w);

        // R7: suspend in the middle of a word slot
        rd_tag = "R7";
        for (int w = 4; w < 8; w++) prog(0, 0, w, 16'(16'h5A00 + w));
        issue(4'b0100, 0, 0, 4, '0, 0, '0);
        repeat (6) @(posedge clk); #1 susp = 1;
        @(posedge clk); #1 susp = 0;
        wait_done();
        for (int w = 4; w < 8; w++) rd(0, 0, w);

        // R7: suspend exactly on the edge that would erase word 1
        for (int w = 8; w < 12; w++) prog(0, 1, w, 16'(16'h3C00 + w));
        issue(4'b0100, 0, 1, 8, '0, 0, '0);
        repeat (2 * EL - 1) @(posedge clk); #1 susp = 1;
        @(posedge clk); #1 susp = 0;
        wait_done();
        for (int w = 8; w < 12; w++) rd(0, 1, w);

        // R8: suspend outside an erase is ignored
        rd_tag = "R8";
        @(posedge clk); #1 susp = 1;
        repeat (3) @(posedge clk); #1;
        issue(4'b0001, 1, 1, 4, '0, 0, '0);
        wait_done();
        issue(4'b0010, 1, 0, 2, 16'hFF0F, 0, '0);
        wait_done();
        #1 susp = 0;
        rd(1, 0, 2);

        // R9: unsupported program type is refused
        rd_tag = "R9";
        issue(4'b0010, 1, 1, 4, 16'h0000, 1, '0);
        wait_done();
        rd(1, 1, 4);
        issue(4'b0010, 0, 0, 1, 16'h0000, 1, '0);
        wait_done();
        rd(0, 0, 1);

        // R10: clear bank 1, then set and clear bank 0 together
        @(posedge clk); #1 eclr = 2'b10;
        @(posedge clk); #1 eclr = 2'b00;
        issue(4'b0010, 0, 0, 2, 16'h0000, 1, 2'b01);
        wait_done();
        repeat (2) @(posedge clk);
        #1 eclr = 2'b01;
        @(posedge clk); #1 eclr = 2'b00;
        repeat (2) @(posedge clk);

        // R6: bank erase of bank 0, bank 1 untouched
        rd_tag = "R6";
        prog(0, 1, 15, 16'h0001);
        issue(4'b1000, 0, 1, 3, '0, 0, '0);
        wait_done();
        rd(0, 0, 5); rd(0, 1, 15); rd(0, 1, 9); rd(1, 1, 4); rd(1, 0, 2);

        repeat (3) @(posedge clk);
        summary();
        $finish;
    end

endmodule